// File: doc/BRIEF.md
# Watchdog Timer with Software Chip Reset

The block is a watchdog counter driven by the system clock. Software sets an enable bit to start it and writes a one to a restart bit to clear it. If software stops restarting it, the counter reaches a terminal count chosen by a period field. It then raises a single-cycle non-maskable interrupt request and drives an overflow status output. That output can work in one of two modes: a pulse of fixed width, or a sticky level that stays high until software restarts the counter or the external reset pin goes low. After an overflow the counter wraps to zero and keeps counting.

The same control register has a chip-reset bit. Writing a one to it asserts an internal reset output on the next cycle. The output is held for a fixed number of cycles, with no oscillator settling delay, and it never reaches the external reset pin. All access goes through one 8-bit register: a write strobe with write data, and read data that is always valid. Clock generation, oscillator settling and the interrupt controller are outside this block.

Top module: `wdt_selfreset`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `nmi_o`, `ovf_o` and `chip_rst_o` are 0 and `rd_data` reads 0x00.
- R2: Register bit layout: bit 0 enable, bit 1 restart (write-one action, always reads 0), bit 2 level mode (1 = level, 0 = pulse), bits 5:3 period select, bit 6 chip reset, bit 7 overflow status (read-only). A write updates enable, mode and period select, and the new values read back on the next cycle.
- R3: While enabled, the counter advances once per cycle. With period select code s, it overflows T cycles after it was cleared, where T = 2^(BASE_EXP+2*s) for s = 0..3 and T = 2^(BASE_EXP+8) for every code of 4 or more. Each overflow makes `nmi_o` high for exactly one cycle, on the cycle after the edge at which the counter held T-1.
- R4: While the enable bit is 0, the counter holds its value and neither `nmi_o` nor a new overflow output is produced.
- R5: Writing 1 to bit 1 clears the counter to zero. If that write coincides with the overflow edge, the restart wins: there is no interrupt and no overflow output, and the next overflow comes a full period later.
- R6: In pulse mode, each overflow drives `ovf_o` high for exactly PULSE_LEN (255) cycles.
- R7: In level mode, an overflow sets `ovf_o`. It stays high until a write with bit 1 set, or until `rst_n` goes low.
- R8: A write with bit 6 set drives `chip_rst_o` high from the next cycle for exactly RST_HOLD (16) cycles. Bit 6 reads 1 while that reset is held and 0 otherwise.
- R9: After an overflow the counter wraps to zero and keeps counting, so an enabled, unrestarted watchdog overflows again every T cycles.
- R10: Bit 7 of `rd_data` always equals `ovf_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | External reset pin, active low, asynchronous |
| wr_en | input | 1 | Write strobe for the control register |
| wr_data | input | 8 | Write data, bit layout as in R2 |
| rd_data | output | 8 | Register read data, bit layout as in R2 |
| nmi_o | output | 1 | Non-maskable interrupt request, one cycle per overflow |
| ovf_o | output | 1 | Overflow status output, pulse or level |
| chip_rst_o | output | 1 | Internal chip reset request, never driven to the pin |

## Verification
The hardest case to reach from the ports is a restart write that lands on the exact edge where the counter holds its terminal value. The bench sets the shortest period and enables the counter with a restart write. It then idles for one cycle less than the period and issues the second restart so that it is sampled on the overflow edge. The bench also runs with a reduced BASE_EXP so that every period code, the wrap, the 255-cycle pulse and the level latch can all be reached in a short run. A behavioural model is compared with every output on every clock.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int REG_W     = 8;
  localparam int SEL_W     = 3;
  localparam int B_EN      = 0;
  localparam int B_RESTART = 1;
  localparam int B_LEVEL   = 2;
  localparam int B_SEL_LO  = 3;
  localparam int B_CHIPRST = 6;
  localparam int B_STATUS  = 7;

  typedef enum logic {
    OVF_PULSE = 1'b0,
    OVF_LEVEL = 1'b1
  } ovf_mode_e;

  typedef struct packed {
    logic             en;
    ovf_mode_e        mode;
    logic [SEL_W-1:0] sel;
  } wdt_cfg_t;
endpackage

// File: rtl/wdt_ctrl_reg.sv
module wdt_ctrl_reg
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             ovf_status,
  input  logic             chip_active,
  output wdt_cfg_t         cfg,
  output logic             restart_p,
  output logic             chip_req,
  output logic [REG_W-1:0] rd_data
);
  // Write-one actions are combinational pulses, sampled downstream on the same edge.
  assign restart_p = wr_en & wr_data[B_RESTART];
  assign chip_req  = wr_en & wr_data[B_CHIPRST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (wr_en) begin
      cfg.en   <= wr_data[B_EN];
      cfg.mode <= ovf_mode_e'(wr_data[B_LEVEL]);
      cfg.sel  <= wr_data[B_SEL_LO +: SEL_W];
    end
  end

  always_comb begin
    rd_data                     = '0;
    rd_data[B_EN]               = cfg.en;
    rd_data[B_LEVEL]            = cfg.mode == OVF_LEVEL;
    rd_data[B_SEL_LO +: SEL_W]  = cfg.sel;
    rd_data[B_CHIPRST]          = chip_active;
    rd_data[B_STATUS]           = ovf_status;
  end
endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
  parameter int BASE_EXP  = 16,
  parameter int STEP      = 2,
  parameter int NUM_STEPS = 5,
  parameter int SEL_W     = 3,
  localparam int CNT_W    = BASE_EXP + STEP * (NUM_STEPS - 1),
  localparam int CODES    = 2 ** SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  input  logic             restart,
  output logic             hit
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] term_tab [CODES];

  // One terminal value per select code; codes past the last step saturate.
  for (genvar g = 0; g < CODES; g++) begin : g_term
    localparam int STEP_IDX = (g < NUM_STEPS - 1) ? g : NUM_STEPS - 1;
    localparam int EXP      = BASE_EXP + STEP * STEP_IDX;
    assign term_tab[g] = CNT_W'((64'd1 << EXP) - 64'd1);
  end

  assign hit = en && !restart && (cnt_q == term_tab[sel]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else if (hit)     cnt_q <= '0;
    else if (en)      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdt_ovf_out.sv
module wdt_ovf_out
  import wdt_pkg::*;
#(
  parameter int PULSE_LEN = 255,
  localparam int PW       = $clog2(PULSE_LEN + 1)
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      hit,
  input  ovf_mode_e mode,
  input  logic      restart,
  output logic      nmi,
  output logic      ovf
);
  logic [PW-1:0] pulse_left;
  logic          latch_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi        <= 1'b0;
      pulse_left <= '0;
      latch_q    <= 1'b0;
    end else begin
      nmi <= hit;
      if (hit && mode == OVF_PULSE)  pulse_left <= PW'(PULSE_LEN);
      else if (pulse_left != '0)     pulse_left <= pulse_left - 1'b1;
      if (restart)                   latch_q <= 1'b0;
      else if (hit && mode == OVF_LEVEL) latch_q <= 1'b1;
    end
  end

  assign ovf = (mode == OVF_LEVEL) ? latch_q : (pulse_left != '0);
endmodule

// File: rtl/wdt_selfrst.sv
module wdt_selfrst #(
  parameter int RST_HOLD = 16,
  localparam int HW      = $clog2(RST_HOLD + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic rst_out
);
  logic [HW-1:0] hold_left;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                hold_left <= '0;
    else if (req)              hold_left <= HW'(RST_HOLD);
    else if (hold_left != '0)  hold_left <= hold_left - 1'b1;
  end

  assign rst_out = hold_left != '0;
endmodule

// File: rtl/wdt_selfreset.sv
module wdt_selfreset
  import wdt_pkg::*;
#(
  parameter int BASE_EXP  = 16,
  parameter int STEP      = 2,
  parameter int NUM_STEPS = 5,
  parameter int PULSE_LEN = 255,
  parameter int RST_HOLD  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic             nmi_o,
  output logic             ovf_o,
  output logic             chip_rst_o
);
  wdt_cfg_t cfg;
  logic     restart_p;
  logic     chip_req;
  logic     hit;

  wdt_ctrl_reg u_reg (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .ovf_status  (ovf_o),
    .chip_active (chip_rst_o),
    .cfg         (cfg),
    .restart_p   (restart_p),
    .chip_req    (chip_req),
    .rd_data     (rd_data)
  );

  wdt_count #(
    .BASE_EXP  (BASE_EXP),
    .STEP      (STEP),
    .NUM_STEPS (NUM_STEPS),
    .SEL_W     (SEL_W)
  ) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (cfg.en),
    .sel     (cfg.sel),
    .restart (restart_p),
    .hit     (hit)
  );

  wdt_ovf_out #(.PULSE_LEN(PULSE_LEN)) u_ovf (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit     (hit),
    .mode    (cfg.mode),
    .restart (restart_p),
    .nmi     (nmi_o),
    .ovf     (ovf_o)
  );

  wdt_selfrst #(.RST_HOLD(RST_HOLD)) u_srst (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (chip_req),
    .rst_out (chip_rst_o)
  );
endmodule

// File: rtl/wdt_selfreset_chk.sv
module wdt_selfreset_chk
  import wdt_pkg::*;
#(
  parameter int RST_HOLD = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [REG_W-1:0] wr_data,
  input logic [REG_W-1:0] rd_data,
  input logic             nmi_o,
  input logic             ovf_o,
  input logic             chip_rst_o
);
  int unsigned hold_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            hold_run <= 0;
    else if (wr_en && wr_data[B_CHIPRST])  hold_run <= 0;
    else if (chip_rst_o)                   hold_run <= hold_run + 1;
    else                                   hold_run <= 0;
  end

  AST_NMI_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_o |=> !nmi_o); // R3
  AST_NMI_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[B_EN] |=> !nmi_o); // R4
  AST_RESTART_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[B_RESTART]) |=> !nmi_o); // R5
  AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[B_LEVEL] && ovf_o && !wr_en) |=> ovf_o); // R7
  AST_CHIPRST_START: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[B_CHIPRST]) |=> chip_rst_o); // R8
  AST_CHIPRST_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    hold_run <= RST_HOLD); // R8
endmodule

bind wdt_selfreset wdt_selfreset_chk #(.RST_HOLD(RST_HOLD)) chk_i (.*);

// File: tb/wdt_selfreset_tb.sv
module wdt_selfreset_tb_top;
  localparam int B     = 4;
  localparam int PLEN  = 255;
  localparam int RHOLD = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       nmi_o, ovf_o, chip_rst_o;

  int checks = 0;
  int errors = 0;
  string phase = "R1";

  wdt_selfreset #(.BASE_EXP(B), .PULSE_LEN(PLEN), .RST_HOLD(RHOLD)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .nmi_o(nmi_o), .ovf_o(ovf_o), .chip_rst_o(chip_rst_o)
  );

  always #2.5 clk = ~clk;

  // Behavioural reference model
  int m_cnt, m_sel, m_pulse, m_hold;
  bit m_en, m_lvl, m_latch, m_nmi;

  function automatic int period(int s);
    return (s >= 4) ? (1 << (B + 8)) : (1 << (B + 2 * s));
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_sel = 0; m_pulse = 0; m_hold = 0;
      m_en = 0; m_lvl = 0; m_latch = 0; m_nmi = 0;
    end else begin
      bit rs, hit;
      rs  = wr_en && wr_data[1];
      hit = m_en && !rs && (m_cnt == period(m_sel) - 1);
      m_nmi = hit;
      if (rs) m_cnt = 0; else if (hit) m_cnt = 0; else if (m_en) m_cnt++;
      if (hit && !m_lvl) m_pulse = PLEN; else if (m_pulse > 0) m_pulse--;
      if (rs) m_latch = 0; else if (hit && m_lvl) m_latch = 1;
      if (wr_en && wr_data[6]) m_hold = RHOLD; else if (m_hold > 0) m_hold--;
      if (wr_en) begin
        m_en = wr_data[0]; m_lvl = wr_data[2]; m_sel = int'(wr_data[5:3]);
      end
    end
  end

  function automatic bit m_ovf();
    return m_lvl ? m_latch : (m_pulse > 0);
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      logic [7:0] exp_rd;
      exp_rd = {m_ovf(), m_hold > 0, m_sel[2:0], m_lvl, 1'b0, m_en};
      check(phase, "nmi_o", nmi_o, m_nmi);
      check(phase, "ovf_o", ovf_o, m_ovf());
      check(phase, "chip_rst_o", chip_rst_o, m_hold > 0);
      check(phase, "rd_data", rd_data, exp_rd);
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  task automatic wr(logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic wait_nmi(int maxc, output int n);
    n = 0;
    do begin
      @(negedge clk); n++;
    end while (!nmi_o && n < maxc);
  endtask

  function automatic logic [7:0] cfgv(bit en, bit rs, bit lv, int s);
    return {2'b00, s[2:0], lv, rs, en};
  endfunction

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check("R1", "nmi_o in reset", nmi_o, 0);
    check("R1", "rd_data in reset", rd_data, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "rd_data after release", rd_data, 0);
    check("R1", "chip_rst_o after release", chip_rst_o, 0);

    phase = "R2";
    wr(cfgv(0, 1, 1, 5));
    check("R2", "readback", rd_data, 8'h2C);
    wr(8'h00);

    phase = "R3";
    wr(cfgv(1, 1, 0, 0));
    wait_nmi(100, n);
    check("R3", "period code 0", n, 16);
    phase = "R9";
    wait_nmi(100, n);
    check("R9", "wrap period", n, 16);
    phase = "R3";
    wr(cfgv(1, 1, 0, 1));
    wait_nmi(1000, n);
    check("R3", "period code 1", n, 64);
    wr(cfgv(1, 1, 0, 2));
    wait_nmi(1000, n);
    check("R3", "period code 2", n, 256);
    wr(cfgv(1, 1, 0, 7));
    wait_nmi(9000, n);
    check("R3", "period code 7 saturates", n, 4096);

    phase = "R6";
    n = 0;
    while (ovf_o) begin n++; @(negedge clk); end
    check("R6", "pulse width", n, PLEN);

    phase = "R4";
    wr(cfgv(0, 1, 0, 0));
    n = 0;
    repeat (200) begin @(negedge clk); if (nmi_o || ovf_o) n++; end
    check("R4", "activity while disabled", n, 0);

    phase = "R5";
    wr(cfgv(1, 1, 0, 0));
    repeat (15) @(negedge clk);
    wr(cfgv(1, 1, 0, 0));
    check("R5", "nmi on coincident restart", nmi_o, 0);
    check("R5", "ovf on coincident restart", ovf_o, 0);
    wait_nmi(100, n);
    check("R5", "next overflow full period", n, 16);
    wr(cfgv(0, 1, 0, 0));
    repeat (PLEN + 2) @(negedge clk);

    phase = "R7";
    wr(cfgv(1, 1, 1, 0));
    wait_nmi(100, n);
    wr(cfgv(0, 0, 1, 0));
    repeat (300) @(negedge clk);
    check("R7", "level held", ovf_o, 1);
    check("R10", "status mirrors ovf", rd_data[7], ovf_o);
    wr(cfgv(0, 1, 1, 0));
    check("R7", "level cleared by restart", ovf_o, 0);
    wr(cfgv(1, 1, 1, 0));
    wait_nmi(100, n);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R7", "level cleared by pin reset", ovf_o, 0);
    rst_n = 1'b1;
    @(negedge clk);

    phase = "R8";
    wr(8'h40);
    check("R8", "chip reset bit reads 1", rd_data[6], 1);
    n = 0;
    while (chip_rst_o && n < 100) begin n++; @(negedge clk); end
    check("R8", "chip reset width", n, RHOLD);
    check("R8", "chip reset bit clears", rd_data[6], 0);
    phase = "R10";
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule